// File: doc/BRIEF.md
# Serial Frame Slot Scheduler

This block sets the frame timing of a synchronous serial host port. The port carries two kinds of 16-bit frames, data frames and control frames. The block runs on the serial bit clock and counts bit positions through a programmable frame period. A data frame starts every period. A control frame can be placed in the slot at the half point of the period, or in the slot at the quarter point. Both frame kinds are shifted in MSB first from the host serial input and handed out as parallel words.

Two policies decide whether the control slot is used. In automatic mode, every period carries a control frame, and all 16 data bits are transmit data. In requested mode, the last bit of each data word is a request flag. The control slot of that period is used only when the flag is 1, and the flag is not passed on as data.

For daisy chaining, the block produces a delayed frame sync one word after the local sync. It also produces output-enable controls for that sync pin and for a clock output pin. A loopback selector feeds the received serial stream to the transmit bit path in place of host data.

The scheduler moves through these states:
- `ST_IDLE`: reset.
- `ST_DATA`: data word shifting.
- `ST_GAP_PRE`: waiting for the control slot.
- `ST_CTRL`: control word shifting.
- `ST_GAP_POST`: waiting for the end of the period.

It makes these transitions:
- IDLE→DATA on the first clock after reset.
- DATA→GAP_PRE when the slot lies later in the period.
- DATA→CTRL when a granted slot starts right after the data word.
- DATA→GAP_POST when no control frame is granted and the slot has already been reached.
- GAP_PRE→CTRL when the slot begins and a control frame is granted.
- GAP_PRE→GAP_POST when the slot begins and no control frame is granted.
- CTRL→GAP_POST after the 16th control bit.
- GAP_POST→DATA at the period wrap.

Top module: `sfs_frame_sched`

## Requirements
- R1: A frame sync pulse (`fs_o`) lasts one clock and marks bit position 0 of each period. The period length is max(`period_i`, 64) clocks. It is sampled at the start of each period and holds for that whole period.
- R2: When `quarter_i` is 0 at the period start, the control sync (`cfs_o`) falls at position floor(N/2), where N is the period length.
- R3: When `quarter_i` is 1 at the period start, the control sync falls at position floor(N/4). For N = 64, this slot begins right after the data word.
- R4: When `hw_ctrl_i` is 1, every period carries a control frame. Bit 0 of the data word is kept in `data_word_o`.
- R5: When `hw_ctrl_i` is 0, the serial bit at position 15 (bit 0 of the data word) is a request. The period carries a control frame only when that bit is 1. `data_word_o[0]` then reads 0.
- R6: A request applies only to the control slot of its own period. A period whose request bit is 0 gets no control frame, even when the previous period requested one.
- R7: Serial input bits at positions 0..15 form the data word, MSB first. `data_valid_o` is high for exactly the one clock at position 16, with the word on `data_word_o`.
- R8: The 16 bits starting at the control slot form the control word, MSB first. `ctl_valid_o` is high for one clock at position slot+16.
- R9: `dfs_oe_o` equals `dfs_en_i`. When enabled, `dfs_o` pulses for one clock at position 16 of each period. Otherwise it stays 0.
- R10: `clko_oe_o` follows `clko_en_i`.
- R11: `tx_bit_o` equals `rx_bit_i` when `loopback_i` is 1, and equals `sdin_i` otherwise.
- R12: While reset is held, no sync, valid or delayed sync output is high. The first frame sync comes in the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_i | input | PW (10) | Requested frame period in clocks |
| quarter_i | input | 1 | Control slot position select: 0 for the half point, 1 for the quarter point |
| hw_ctrl_i | input | 1 | 1 for automatic control frames, 0 for requested control frames |
| dfs_en_i | input | 1 | Delayed frame sync enable |
| clko_en_i | input | 1 | Clock output enable |
| loopback_i | input | 1 | Route the received stream to the transmit bit path |
| sdin_i | input | 1 | Host serial data input |
| rx_bit_i | input | 1 | Received serial bit stream |
| fs_o | output | 1 | Data frame sync |
| cfs_o | output | 1 | Control frame sync |
| dfs_o | output | 1 | Delayed frame sync level |
| dfs_oe_o | output | 1 | Output enable for the delayed sync pin |
| clko_oe_o | output | 1 | Output enable for the clock output pin |
| tx_bit_o | output | 1 | Bit delivered to the transmit path |
| data_word_o | output | W (16) | Last captured data word |
| data_valid_o | output | 1 | Data word strobe |
| ctl_word_o | output | W (16) | Last captured control word |
| ctl_valid_o | output | 1 | Control word strobe |

## Verification
The hardest case to reach is a request bit arriving on the last data bit when the control slot starts on the very next clock. This happens in requested mode at the minimum period with the quarter slot selected. The bench reaches it by setting the period to 64 with the quarter slot, then driving the request bit at position 15 from its own position tracker. It uses always-one, always-zero and alternating request patterns. The alternating pattern also shows that a request does not carry into the following period.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_GAP_PRE,
        ST_CTRL,
        ST_GAP_POST
    } slot_state_t;

    localparam int CAP_DATA  = 0;
    localparam int CAP_CTRL  = 1;
    localparam int CAP_KINDS = 2;

endpackage

// File: rtl/sfs_slot_fsm.sv
module sfs_slot_fsm
    import sfs_pkg::*;
#(
    parameter int W  = 16,
    parameter int PW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period_i,
    input  logic          quarter_i,
    input  logic          hw_i,
    input  logic          sdin_i,
    output logic          fs_o,
    output logic          cfs_o,
    output logic          dfs_pulse_o,
    output logic          data_shift_o,
    output logic          data_last_o,
    output logic          ctl_shift_o,
    output logic          ctl_last_o
);

    localparam logic [PW-1:0] MIN_PER = PW'(4 * W);
    localparam logic [PW-1:0] WORD    = PW'(W);
    localparam logic [PW:0]   WORD_X  = (PW+1)'(W);

    slot_state_t   state_q, state_n;
    logic [PW-1:0] pos_q, pos_n, pos_inc;
    logic [PW-1:0] per_q, slot_q;
    logic [PW-1:0] per_clamp;
    logic          req_q, req_now;
    logic          wrap, data_end, inc_in_win;
    logic [PW:0]   win_end;

    assign per_clamp  = (period_i < MIN_PER) ? MIN_PER : period_i;
    assign wrap       = (state_q != ST_IDLE) && (pos_q == per_q - 1'b1);
    assign data_end   = (state_q == ST_DATA) && (pos_q == WORD - 1'b1);
    assign req_now    = data_end ? (hw_i | sdin_i) : req_q;
    assign pos_inc    = pos_q + 1'b1;
    assign win_end    = {1'b0, slot_q} + WORD_X;
    assign inc_in_win = ({1'b0, pos_inc} >= {1'b0, slot_q}) &&
                        ({1'b0, pos_inc} < win_end);

    // next-state process
    always_comb begin
        state_n = state_q;
        pos_n   = pos_q;
        unique case (state_q)
            ST_IDLE: begin
                state_n = ST_DATA;
                pos_n   = '0;
            end
            ST_DATA, ST_GAP_PRE, ST_CTRL, ST_GAP_POST: begin
                if (wrap) begin
                    state_n = ST_DATA;
                    pos_n   = '0;
                end else begin
                    pos_n = pos_inc;
                    if (pos_inc < WORD)
                        state_n = ST_DATA;
                    else if (req_now && inc_in_win)
                        state_n = ST_CTRL;
                    else if (pos_inc < slot_q)
                        state_n = ST_GAP_PRE;
                    else
                        state_n = ST_GAP_POST;
                end
            end
            default: begin
                state_n = ST_IDLE;
                pos_n   = '0;
            end
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            per_q   <= MIN_PER;
            slot_q  <= '0;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            pos_q   <= pos_n;
            if (state_q == ST_IDLE || wrap) begin
                per_q  <= per_clamp;
                slot_q <= quarter_i ? (per_clamp >> 2) : (per_clamp >> 1);
            end
            if (wrap)
                req_q <= 1'b0;
            else if (data_end)
                req_q <= hw_i | sdin_i;
        end
    end

    // output process
    always_comb begin
        fs_o         = (state_q == ST_DATA) && (pos_q == '0);
        cfs_o        = (state_q == ST_CTRL) && (pos_q == slot_q);
        dfs_pulse_o  = (state_q != ST_IDLE) && (pos_q == WORD);
        data_shift_o = (state_q == ST_DATA);
        data_last_o  = data_end;
        ctl_shift_o  = (state_q == ST_CTRL);
        ctl_last_o   = (state_q == ST_CTRL) && ({1'b0, pos_q} == win_end - 1'b1);
    end

    a_r1_fs_single: assert property (@(posedge clk) disable iff (!rst_n)
        fs_o |=> !fs_o);
    a_r5_cfs_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        cfs_o |-> req_q);
    a_r7_data_word_closes: assert property (@(posedge clk) disable iff (!rst_n)
        data_last_o |=> !data_shift_o);
    a_r8_ctl_begins_at_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_shift_o) |-> cfs_o);
    a_r9_dfs_apart_from_fs: assert property (@(posedge clk) disable iff (!rst_n)
        fs_o |-> !dfs_pulse_o);

endmodule

// File: rtl/sfs_word_capture.sv
module sfs_word_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         last_i,
    input  logic         mask_lsb_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o,
    output logic         valid_o
);

    logic [W-1:0] sh_q;
    logic [W-1:0] full;

    assign full = {sh_q[W-2:0], bit_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= last_i;
            if (shift_i)
                sh_q <= full;
            if (last_i)
                word_o <= {full[W-1:1], full[0] & ~mask_lsb_i};
        end
    end

    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    a_r8_last_while_shifting: assert property (@(posedge clk) disable iff (!rst_n)
        last_i |-> shift_i);

endmodule

// File: rtl/sfs_pin_ctl.sv
module sfs_pin_ctl (
    input  logic dfs_en_i,
    input  logic clko_en_i,
    input  logic loopback_i,
    input  logic sdin_i,
    input  logic rx_bit_i,
    input  logic dfs_pulse_i,
    output logic dfs_o,
    output logic dfs_oe_o,
    output logic clko_oe_o,
    output logic tx_bit_o
);

    always_comb begin
        dfs_oe_o  = dfs_en_i;
        dfs_o     = dfs_en_i & dfs_pulse_i;
        clko_oe_o = clko_en_i;
        tx_bit_o  = loopback_i ? rx_bit_i : sdin_i;
    end

endmodule

// File: rtl/sfs_frame_sched.sv
module sfs_frame_sched
    import sfs_pkg::*;
#(
    parameter int W  = 16,
    parameter int PW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period_i,
    input  logic          quarter_i,
    input  logic          hw_ctrl_i,
    input  logic          dfs_en_i,
    input  logic          clko_en_i,
    input  logic          loopback_i,
    input  logic          sdin_i,
    input  logic          rx_bit_i,
    output logic          fs_o,
    output logic          cfs_o,
    output logic          dfs_o,
    output logic          dfs_oe_o,
    output logic          clko_oe_o,
    output logic          tx_bit_o,
    output logic [W-1:0]  data_word_o,
    output logic          data_valid_o,
    output logic [W-1:0]  ctl_word_o,
    output logic          ctl_valid_o
);

    logic                 dfs_pulse;
    logic [CAP_KINDS-1:0] shift_v, last_v, mask_v, valid_v;
    logic [W-1:0]         word_v [CAP_KINDS];

    sfs_slot_fsm #(.W(W), .PW(PW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_i     (period_i),
        .quarter_i    (quarter_i),
        .hw_i         (hw_ctrl_i),
        .sdin_i       (sdin_i),
        .fs_o         (fs_o),
        .cfs_o        (cfs_o),
        .dfs_pulse_o  (dfs_pulse),
        .data_shift_o (shift_v[CAP_DATA]),
        .data_last_o  (last_v[CAP_DATA]),
        .ctl_shift_o  (shift_v[CAP_CTRL]),
        .ctl_last_o   (last_v[CAP_CTRL])
    );

    assign mask_v[CAP_DATA] = ~hw_ctrl_i;
    assign mask_v[CAP_CTRL] = 1'b0;

    for (genvar k = 0; k < CAP_KINDS; k++) begin : g_cap
        sfs_word_capture #(.W(W)) u_cap (
            .clk        (clk),
            .rst_n      (rst_n),
            .shift_i    (shift_v[k]),
            .last_i     (last_v[k]),
            .mask_lsb_i (mask_v[k]),
            .bit_i      (sdin_i),
            .word_o     (word_v[k]),
            .valid_o    (valid_v[k])
        );
    end

    assign data_word_o  = word_v[CAP_DATA];
    assign data_valid_o = valid_v[CAP_DATA];
    assign ctl_word_o   = word_v[CAP_CTRL];
    assign ctl_valid_o  = valid_v[CAP_CTRL];

    sfs_pin_ctl u_pins (
        .dfs_en_i    (dfs_en_i),
        .clko_en_i   (clko_en_i),
        .loopback_i  (loopback_i),
        .sdin_i      (sdin_i),
        .rx_bit_i    (rx_bit_i),
        .dfs_pulse_i (dfs_pulse),
        .dfs_o       (dfs_o),
        .dfs_oe_o    (dfs_oe_o),
        .clko_oe_o   (clko_oe_o),
        .tx_bit_o    (tx_bit_o)
    );

    a_r9_dfs_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        dfs_o |-> dfs_oe_o);
    a_r11_loop_path: assert property (@(posedge clk) disable iff (!rst_n)
        loopback_i |-> (tx_bit_o == rx_bit_i));
    a_r8_ctl_valid_not_data: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_valid_o |-> !fs_o);

endmodule

// File: tb/sfs_frame_sched_test.sv
`timescale 1ns/1ps
module sfs_frame_sched_test;

    localparam int W  = 16;
    localparam int PW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] period_i = 10'd100;
    logic          quarter_i = 1'b0, hw_ctrl_i = 1'b0, dfs_en_i = 1'b0;
    logic          clko_en_i = 1'b0, loopback_i = 1'b0, sdin_i = 1'b0, rx_bit_i = 1'b0;
    logic          fs_o, cfs_o, dfs_o, dfs_oe_o, clko_oe_o, tx_bit_o;
    logic [W-1:0]  data_word_o, ctl_word_o;
    logic          data_valid_o, ctl_valid_o;

    sfs_frame_sched #(.W(W), .PW(PW)) uut (.*);

    always #2 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // behavioural reference model
    int          m_started, m_pos, m_per, m_slot, m_req;
    logic [15:0] m_dsh, m_csh, m_dword, m_cword;
    bit          m_dv, m_cv;

    task automatic m_load();
        m_per  = (int'(period_i) < 4*W) ? 4*W : int'(period_i);
        m_slot = quarter_i ? m_per / 4 : m_per / 2;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_started = 0; m_pos = 0; m_req = 0; m_dv = 0; m_cv = 0;
            m_dsh = '0; m_csh = '0; m_dword = '0; m_cword = '0;
        end else begin
            m_dv = 0;
            m_cv = 0;
            if (m_started == 0) begin
                m_started = 1; m_pos = 0; m_req = 0; m_load();
            end else begin
                if (m_pos < W) begin
                    m_dsh = {m_dsh[14:0], sdin_i};
                    if (m_pos == W-1) begin
                        m_dword = m_dsh;
                        if (!hw_ctrl_i) m_dword[0] = 1'b0;
                        m_dv  = 1;
                        m_req = (hw_ctrl_i || sdin_i) ? 1 : 0;
                    end
                end else if (m_req != 0 && m_pos >= m_slot && m_pos < m_slot + W) begin
                    m_csh = {m_csh[14:0], sdin_i};
                    if (m_pos == m_slot + W - 1) begin
                        m_cword = m_csh;
                        m_cv    = 1;
                    end
                end
                if (m_pos == m_per - 1) begin
                    m_pos = 0; m_req = 0; m_load();
                end else begin
                    m_pos++;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("R1 R12 fs_o", 16'(fs_o), 16'(m_started != 0 && m_pos == 0));
            chk(quarter_i ? "R3 R4 R5 R6 cfs_o" : "R2 R4 R5 R6 cfs_o", 16'(cfs_o),
                16'(m_started != 0 && m_req != 0 && m_pos == m_slot));
            chk("R9 R12 dfs_o", 16'(dfs_o), 16'(dfs_en_i && m_started != 0 && m_pos == W));
            chk("R9 dfs_oe_o", 16'(dfs_oe_o), 16'(dfs_en_i));
            chk("R10 clko_oe_o", 16'(clko_oe_o), 16'(clko_en_i));
            chk("R11 tx_bit_o", 16'(tx_bit_o), 16'(loopback_i ? rx_bit_i : sdin_i));
            chk("R7 R12 data_valid_o", 16'(data_valid_o), 16'(m_dv));
            chk("R8 R12 ctl_valid_o", 16'(ctl_valid_o), 16'(m_cv));
            if (m_dv) chk("R4 R5 R7 data_word_o", data_word_o, m_dword);
            if (m_cv) chk("R8 ctl_word_o", ctl_word_o, m_cword);
        end
    end

    // req_mode: 0 random, 1 request always, 2 never, 3 alternate per period
    task automatic run(input int n, input int req_mode);
        bit alt = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            sdin_i   = 1'($urandom);
            rx_bit_i = 1'($urandom);
            if (m_pos == W-1 && m_started != 0) begin
                case (req_mode)
                    1: sdin_i = 1'b1;
                    2: sdin_i = 1'b0;
                    3: begin sdin_i = alt; alt = ~alt; end
                    default: ;
                endcase
            end
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        run(6, 0);                                   // R12 reset state
        @(posedge clk); #1; rst_n = 1'b1;
        run(300, 1);                                 // R2 R5 requests granted
        run(300, 2);                                 // R5 no requests
        run(500, 3);                                 // R6 alternating requests
        @(posedge clk); #1; quarter_i = 1'b1; period_i = 10'd64;
        run(400, 3);                                 // R3 adjacent slot at minimum period
        run(200, 0);
        @(posedge clk); #1; hw_ctrl_i = 1'b1; period_i = 10'd70;
        run(300, 2);                                 // R4 automatic, bit 0 kept
        @(posedge clk); #1; quarter_i = 1'b0; period_i = 10'd99;
        run(300, 0);                                 // R2 R4 odd period
        @(posedge clk); #1; hw_ctrl_i = 1'b0; period_i = 10'd40;
        run(250, 0);                                 // R1 clamp to 64
        @(posedge clk); #1; dfs_en_i = 1'b1; period_i = 10'd128;
        run(300, 0);                                 // R9
        @(posedge clk); #1; clko_en_i = 1'b1;
        run(100, 0);                                 // R10
        @(posedge clk); #1; loopback_i = 1'b1;
        run(150, 0);                                 // R11
        @(posedge clk); #1; loopback_i = 1'b0; dfs_en_i = 1'b0; clko_en_i = 1'b0;
        run(150, 0);
        @(posedge clk); #1;
        finish_run();
    end

endmodule